// File: doc/BRIEF.md
# Programmable Clock Divider Bank with Output Crosspoint

This core spreads one fast clock over six outputs. Two divider banks run from the fast clock. Each bank has a programmable integer divider and two fixed taps: bank 1 divides by 2 and by 3, bank 2 by 2 and by 4. A slower reference clock is first synchronized into the fast domain and then offered as one more source. Each output has a 3-bit selector that picks one of these seven sources, and each output has its own enable.

All settings sit behind a byte-wide write port with a combinational read port. The divisors, the packed selector fields and the enable bits can be read back. Reserved addresses reject writes and report them through a sticky flag. Divisor updates are applied at the bank's next terminal count, so the divider output and its taps keep a common rising edge. Source and enable changes are applied to an output only while the output and its new source are both low, so no output ever produces a shortened pulse.

Top module: `clk_xbar_div`

## Requirements
- R1: After reset the bank-1 and bank-2 divisors read 8. The selector and enable registers read 0x00. `cfg_err` is 0 and every `clk_out` bit is low.
- R2: Bank-1 divisor N1 is read and written at 0x0C, and bank-2 divisor N2 at 0x47; both read back as {1'b0, N}. The enables sit in bits 5:0 of 0x09, bit i enabling `clk_out[i]`, and bits 7:6 of 0x09 read 0.
- R3: A divisor write below 4 stores 4, a write above 127 stores 127, and any value in 4..127 is stored unchanged.
- R4: The six 3-bit selectors are packed MSB-first in output order, with output 1 being `clk_out[0]`. 0x44 holds {sel1, sel2, sel3[2:1]}, 0x45 holds {sel3[0], sel4, sel5, sel6[2]}, and 0x46[7:6] holds sel6[1:0]. 0x46[5:0] reads 0.
- R5: A write to a reserved address (0x00-0x08, 0x0A-0x0B, 0x0D-0x11, 0x14-0x3F, 0x43, 0x48-0xFF) changes no setting and sets `cfg_err` from the next cycle on. The flag stays set until reset. A read of a reserved address returns 0x00.
- R6: Selector code 001 gives a fast-clock divide by N1 and code 100 a divide by N2. The period is N fast cycles and the high time is ceil(N/2) cycles.
- R7: The fixed taps follow the fast clock. Codes 010 and 101 give period 2 with high time 1. Code 011 gives period 3 with high time 2. Code 110 gives period 4 with high time 2.
- R8: Code 000 routes the reference clock through a two-stage synchronizer. Its period and high time are kept, measured in fast cycles.
- R9: When N1 is a multiple of 4, every rising edge of the divide-by-N1 output coincides with a rising edge of the bank-1 divide-by-2 output. When N1 is 6, it coincides with a rising edge of the divide-by-3 output.
- R10: When N2 is a multiple of 4, every rising edge of the divide-by-N2 output coincides with a rising edge of the bank-2 divide-by-2 output. When N2 is a multiple of 8, it coincides with a rising edge of the divide-by-4 output.
- R11: A new divisor takes effect at the bank's next terminal count. The bank's divider and tap counters all restart in that same cycle.
- R12: An output whose enable is 0, or whose selector is 111, stays low.
- R13: A new source or enable is applied to an output only in a cycle where the output is low and the new source is low. Every high pulse is therefore a full pulse of either the old source or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock that feeds both divider banks |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock, selectable as source 000 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| cfg_err | output | 1 | Sticky flag for a write to a reserved address |
| clk_out | output | 6 | Routed and gated output clocks, output 1 at bit 0 |

## Verification
Read data follows the address in the same cycle. `cfg_err` rises one edge after the write. Each output follows its selected source by one fast cycle, and the reference clock reaches an output three cycles after it changes. The bench drives inputs and samples on the falling edge. After each configuration write it waits a settling window, which covers the longest terminal-count wait and the low-phase handover, before it measures whole periods, high times and coincident rising edges. The pulse-length scan runs alongside the selector write, so any pulse cut short during a handover is caught as it happens.

// File: rtl/clk_xbar_div.sv
module clk_xbar_div #(
  parameter int NW   = 7,
  parameter int NMIN = 4,
  parameter int NMAX = 127,
  parameter int NRST = 8
) (
  input  logic       clk_fast,
  input  logic       rst_n,
  input  logic       ref_clk,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       cfg_err,
  output logic [5:0] clk_out
);
  localparam int NOUT = 6;
  localparam int SELW = 3 * NOUT;
  localparam logic [7:0] A_EN = 8'h09;
  localparam logic [7:0] A_N1 = 8'h0C;
  localparam logic [7:0] A_N2 = 8'h47;
  localparam logic [7:0] A_S0 = 8'h44;
  localparam logic [7:0] A_S1 = 8'h45;
  localparam logic [7:0] A_S2 = 8'h46;

  logic [NW-1:0]   n1_q, n2_q, n1_act, n2_act, cnt1, cnt2;
  logic [NW:0]     hi1, hi2;
  logic [SELW-1:0] sel_q, act_sel;
  logic [NOUT-1:0] en_q, act_en;
  logic [1:0]      ref_sync, t13, t24;
  logic            t12, t22, rsv, term1, term2;
  logic [7:0]      src;

  function automatic logic [NW-1:0] clampn(input logic [7:0] w);
    if (w < 8'(NMIN)) return NW'(NMIN);
    if (w > 8'(NMAX)) return NW'(NMAX);
    return w[NW-1:0];
  endfunction

  assign rsv = (reg_addr <= 8'h08) || (reg_addr == 8'h43) || (reg_addr >= 8'h48) ||
               (reg_addr inside {[8'h0A:8'h0B], [8'h0D:8'h11], [8'h14:8'h3F]});

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      n1_q    <= NW'(NRST);
      n2_q    <= NW'(NRST);
      sel_q   <= '0;
      en_q    <= '0;
      cfg_err <= 1'b0;
    end else if (reg_we) begin
      if (rsv) cfg_err <= 1'b1;
      case (reg_addr)
        A_EN: en_q <= reg_wdata[NOUT-1:0];
        A_N1: n1_q <= clampn(reg_wdata);
        A_N2: n2_q <= clampn(reg_wdata);
        A_S0: sel_q[SELW-1 -: 8] <= reg_wdata;
        A_S1: sel_q[SELW-9 -: 8] <= reg_wdata;
        A_S2: sel_q[1:0] <= reg_wdata[7:6];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_EN:    reg_rdata = 8'(en_q);
      A_N1:    reg_rdata = 8'(n1_q);
      A_N2:    reg_rdata = 8'(n2_q);
      A_S0:    reg_rdata = sel_q[SELW-1 -: 8];
      A_S1:    reg_rdata = sel_q[SELW-9 -: 8];
      A_S2:    reg_rdata = {sel_q[1:0], 6'b0};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk_fast or negedge rst_n)
    if (!rst_n) ref_sync <= '0;
    else        ref_sync <= {ref_sync[0], ref_clk};

  // bank 1: divide by N1, taps /2 and /3
  assign term1 = (cnt1 == n1_act - 1'b1);
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      cnt1 <= '0; n1_act <= NW'(NRST); t12 <= 1'b0; t13 <= '0;
    end else if (term1 && n1_q != n1_act) begin
      cnt1 <= '0; n1_act <= n1_q; t12 <= 1'b0; t13 <= '0;
    end else begin
      cnt1 <= term1 ? '0 : cnt1 + 1'b1;
      t12  <= ~t12;
      t13  <= (t13 == 2'd2) ? 2'd0 : t13 + 2'd1;
    end
  end

  // bank 2: divide by N2, taps /2 and /4
  assign term2 = (cnt2 == n2_act - 1'b1);
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      cnt2 <= '0; n2_act <= NW'(NRST); t22 <= 1'b0; t24 <= '0;
    end else if (term2 && n2_q != n2_act) begin
      cnt2 <= '0; n2_act <= n2_q; t22 <= 1'b0; t24 <= '0;
    end else begin
      cnt2 <= term2 ? '0 : cnt2 + 1'b1;
      t22  <= ~t22;
      t24  <= t24 + 2'd1;
    end
  end

  assign hi1 = ({1'b0, n1_act} + 1'b1) >> 1;
  assign hi2 = ({1'b0, n2_act} + 1'b1) >> 1;

  assign src[0] = ref_sync[1];
  assign src[1] = {1'b0, cnt1} < hi1;
  assign src[2] = ~t12;
  assign src[3] = (t13 != 2'd2);
  assign src[4] = {1'b0, cnt2} < hi2;
  assign src[5] = ~t22;
  assign src[6] = ~t24[1];
  assign src[7] = 1'b0;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    logic [2:0] s_new, s_act;
    logic       e_act, o_q, v_new, v_act, differ;
    assign s_new  = sel_q[SELW-1-3*i -: 3];
    assign v_new  = en_q[i] & src[s_new];
    assign v_act  = e_act & src[s_act];
    assign differ = (s_act != s_new) || (e_act != en_q[i]);
    always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) begin
        s_act <= '0; e_act <= 1'b0; o_q <= 1'b0;
      end else if (differ && !o_q && !v_new) begin
        s_act <= s_new; e_act <= en_q[i]; o_q <= 1'b0;
      end else begin
        o_q <= v_act;
      end
    end
    assign act_sel[SELW-1-3*i -: 3] = s_act;
    assign act_en[i]  = e_act;
    assign clk_out[i] = o_q;
  end
endmodule

// File: rtl/clk_xbar_div_chk.sv
module clk_xbar_div_chk #(
  parameter int NW = 7
) (
  input logic          clk_fast,
  input logic          rst_n,
  input logic          reg_we,
  input logic [7:0]    reg_addr,
  input logic          cfg_err,
  input logic [5:0]    clk_out,
  input logic [17:0]   act_sel,
  input logic [5:0]    act_en,
  input logic [NW-1:0] n1_q,
  input logic [NW-1:0] n1_act,
  input logic [NW-1:0] n2_act,
  input logic [NW-1:0] cnt1,
  input logic [7:0]    src
);
  logic bad_addr;
  assign bad_addr = (reg_addr < 8'h09) || (reg_addr == 8'h0A) || (reg_addr == 8'h0B) ||
                    (reg_addr >= 8'h0D && reg_addr <= 8'h11) ||
                    (reg_addr >= 8'h14 && reg_addr <= 8'h3F) ||
                    (reg_addr == 8'h43) || (reg_addr > 8'h47);

  // R5
  rsv_flag_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    reg_we && bad_addr |=> cfg_err);
  // R5
  err_sticky_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R3
  n1_range_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    reg_we && reg_addr == 8'h0C |=> n1_q >= NW'(4) && n1_q <= NW'(127));
  // R11
  reload_restart_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(n1_act) |-> cnt1 == '0 && src[2] && src[3]);
  // R9
  b1_align_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(src[1]) && n1_act[1:0] == 2'b00 |-> src[2]);
  // R10
  b2_align_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(src[4]) && n2_act[2:0] == 3'b000 |-> src[5] && src[6]);

  for (genvar i = 0; i < 6; i++) begin : g_chk
    // R12
    off_low_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (!act_en[i] || act_sel[17-3*i -: 3] == 3'b111) |=> !clk_out[i]);
    // R13
    swap_low_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (!$stable(act_sel[17-3*i -: 3]) || !$stable(act_en[i])) |-> !clk_out[i] && !$past(clk_out[i]));
  end
endmodule

bind clk_xbar_div clk_xbar_div_chk #(.NW(NW)) u_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .cfg_err(cfg_err), .clk_out(clk_out), .act_sel(act_sel), .act_en(act_en),
  .n1_q(n1_q), .n1_act(n1_act), .n2_act(n2_act), .cnt1(cnt1), .src(src)
);

// File: tb/test_clk_xbar_div.sv
`timescale 1ns/1ps
module test_clk_xbar_div;
  logic clk_fast = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic cfg_err;
  logic [5:0] clk_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  clk_xbar_div i_clk_xbar_div (
    .clk_fast(clk_fast), .rst_n(rst_n), .ref_clk(ref_clk), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_err(cfg_err), .clk_out(clk_out)
  );

  always #4 clk_fast = ~clk_fast;
  initial begin #2; forever #40 ref_clk = ~ref_clk; end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_fast);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_fast); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_fast); reg_we = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk_fast); reg_addr = a; #1;
    check(req, int'(reg_rdata), int'(exp));
  endtask

  function automatic logic [6:0] clampn(input logic [7:0] w);
    if (w < 8'd4) return 7'd4;
    if (w > 8'd127) return 7'd127;
    return w[6:0];
  endfunction

  task automatic wr_sel(input logic [2:0] s0, s1, s2, s3, s4, s5, input logic [5:0] junk);
    wr(8'h44, {s0, s1, s2[2:1]});
    wr(8'h45, {s2[0], s3, s4, s5[2]});
    wr(8'h46, {s5[1:0], junk});
  endtask

  task automatic exp_wave(input logic [2:0] code, input int n1, input int n2, output int per, output int hi);
    case (code)
      3'd0: begin per = 10; hi = 5; end
      3'd1: begin per = n1; hi = (n1 + 1) / 2; end
      3'd2, 3'd5: begin per = 2; hi = 1; end
      3'd3: begin per = 3; hi = 2; end
      3'd4: begin per = n2; hi = (n2 + 1) / 2; end
      default: begin per = 4; hi = 2; end
    endcase
  endtask

  task automatic measure(input int idx, input int per, input int hi, input string req);
    int c, h, p; logic pv;
    c = 0; pv = 1'b1;
    forever begin
      @(negedge clk_fast); c++;
      if (!pv && clk_out[idx]) break;
      pv = clk_out[idx];
      if (c > 1000) break;
    end
    h = 1; p = 1; pv = 1'b1;
    forever begin
      @(negedge clk_fast);
      if (!pv && clk_out[idx]) break;
      if (clk_out[idx]) h++;
      p++; pv = clk_out[idx];
      if (p > 1000) break;
    end
    check({req, " period"}, p, per);
    check({req, " high"}, h, hi);
  endtask

  task automatic low_for(input int idx, input int n, input string req);
    int highs = 0;
    repeat (n) begin @(negedge clk_fast); if (clk_out[idx]) highs++; end
    check(req, highs, 0);
  endtask

  task automatic align(input int a, input int b, input string req);
    int rises = 0, miss = 0; logic pa, pb;
    pa = clk_out[a]; pb = clk_out[b];
    repeat (200) begin
      @(negedge clk_fast);
      if (!pa && clk_out[a]) begin rises++; if (!(!pb && clk_out[b])) miss++; end
      pa = clk_out[a]; pb = clk_out[b];
    end
    check({req, " misses"}, miss, 0);
    check({req, " saw rises"}, int'(rises > 0), 1);
  endtask

  task automatic pulse_scan(input int idx, input int n, input int la, input int lb, input string req);
    int len = 0, bad = 0; bit inp = 1'b0; logic pv;
    pv = clk_out[idx];
    repeat (n) begin
      @(negedge clk_fast);
      if (!pv && clk_out[idx]) begin inp = 1'b1; len = 1; end
      else if (pv && clk_out[idx] && inp) len++;
      else if (pv && !clk_out[idx] && inp) begin
        if (len != la && len != lb) bad++;
        inp = 1'b0;
      end
      pv = clk_out[idx];
    end
    check(req, bad, 0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, hi;
    void'($urandom(32'd5150));
    idle(5);
    check("R1 outputs low", int'(clk_out), 0);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rdchk("R1 N1", 8'h0C, 8'd8);
    rdchk("R1 N2", 8'h47, 8'd8);
    rdchk("R1 enables", 8'h09, 8'h00);
    rdchk("R1 sel0", 8'h44, 8'h00);
    rdchk("R1 sel1", 8'h45, 8'h00);
    rdchk("R1 sel2", 8'h46, 8'h00);
    check("R1 err", int'(cfg_err), 0);
    check("R1 outputs", int'(clk_out), 0);

    // R2 register map
    wr(8'h09, 8'hFF); rdchk("R2 enable bits", 8'h09, 8'h3F);
    wr(8'h0C, 8'd37); rdchk("R2 N1", 8'h0C, 8'd37);
    wr(8'h47, 8'd100); rdchk("R2 N2", 8'h47, 8'd100);
    // R3 clamping
    wr(8'h0C, 8'd2);   rdchk("R3 low clamp N1", 8'h0C, 8'd4);
    wr(8'h0C, 8'd200); rdchk("R3 high clamp N1", 8'h0C, 8'd127);
    wr(8'h47, 8'd0);   rdchk("R3 low clamp N2", 8'h47, 8'd4);
    wr(8'h47, 8'd128); rdchk("R3 high clamp N2", 8'h47, 8'd127);
    // R4 packing, junk in 0x46 low bits
    wr_sel(3'd1, 3'd2, 3'd5, 3'd3, 3'd6, 3'd5, 6'h2A);
    rdchk("R4 byte0", 8'h44, {3'd1, 3'd2, 2'b10});
    rdchk("R4 byte1", 8'h45, {1'b1, 3'd3, 3'd6, 1'b1});
    rdchk("R4 byte2", 8'h46, {2'b01, 6'b0});
    check("R5 no err on legal writes", int'(cfg_err), 0);
    // R5 reserved addresses
    wr(8'h43, 8'h55);
    check("R5 err set", int'(cfg_err), 1);
    rdchk("R5 read 0x43", 8'h43, 8'h00);
    wr(8'h05, 8'h11); rdchk("R5 read 0x05", 8'h05, 8'h00);
    wr(8'h90, 8'h7E); rdchk("R5 read 0x90", 8'h90, 8'h00);
    rdchk("R5 N1 untouched", 8'h0C, 8'd127);
    rdchk("R5 enables untouched", 8'h09, 8'h3F);
    wr(8'h0C, 8'd9);
    check("R5 err sticky", int'(cfg_err), 1);

    // R6 R7 R8 waveforms
    wr(8'h47, 8'd10);
    wr_sel(3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 6'h0);
    idle(300);
    measure(0, 10, 5, "R8 ref");
    measure(1, 9, 5, "R6 odd N1");
    measure(2, 2, 1, "R7 b1 div2");
    measure(3, 3, 2, "R7 b1 div3");
    measure(4, 2, 1, "R7 b2 div2");
    measure(5, 4, 2, "R7 b2 div4");
    wr_sel(3'd4, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 6'h0);
    idle(300);
    measure(0, 10, 5, "R6 even N2");

    // R11 R9 reload from odd N restores alignment
    wr_sel(3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 6'h0);
    wr(8'h0C, 8'd12);
    idle(300);
    measure(0, 12, 6, "R11 new N1");
    align(0, 1, "R9 N1=12 div2");
    wr(8'h0C, 8'd6);
    idle(300);
    align(0, 2, "R9 N1=6 div3");
    // R10
    wr(8'h47, 8'd16);
    idle(300);
    align(3, 4, "R10 N2=16 div2");
    align(3, 5, "R10 N2=16 div4");
    wr(8'h47, 8'd12);
    idle(300);
    align(3, 4, "R10 N2=12 div2");

    // R12
    wr(8'h09, 8'h3E);
    idle(50);
    low_for(0, 300, "R12 disabled");
    wr(8'h09, 8'h3F);
    wr_sel(3'd7, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 6'h0);
    idle(50);
    low_for(0, 300, "R12 code 111");

    // R13 handover keeps whole pulses
    wr(8'h0C, 8'd40);
    wr_sel(3'd0, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 6'h0);
    idle(300);
    fork
      pulse_scan(0, 400, 5, 20, "R13 ref to N1");
      begin idle(37); wr(8'h44, {3'd1, 3'd2, 2'b01}); end
    join
    fork
      pulse_scan(0, 400, 5, 20, "R13 N1 to ref");
      begin idle(53); wr(8'h44, {3'd0, 3'd2, 2'b01}); end
    join

    // random configurations: R3 R4 R6 R7 R8 R12
    for (int it = 0; it < 8; it++) begin
      logic [7:0] w1, w2; logic [2:0] s [6]; logic [5:0] en;
      int n1, n2;
      w1 = 8'($urandom); w2 = 8'($urandom); en = 6'($urandom);
      for (int k = 0; k < 6; k++) s[k] = 3'($urandom);
      n1 = int'(clampn(w1)); n2 = int'(clampn(w2));
      wr(8'h0C, w1); wr(8'h47, w2); wr(8'h09, {2'b11, en});
      wr_sel(s[0], s[1], s[2], s[3], s[4], s[5], 6'($urandom));
      rdchk("R3 random N1", 8'h0C, 8'(n1));
      rdchk("R3 random N2", 8'h47, 8'(n2));
      rdchk("R4 random byte1", 8'h45, {s[2][0], s[3], s[4], s[5][2]});
      idle(300);
      for (int k = 0; k < 6; k++) begin
        if (!en[k] || s[k] == 3'd7) low_for(k, 150, "R12 random off");
        else begin
          exp_wave(s[k], n1, n2, per, hi);
          measure(k, per, hi, "R6 R7 R8 random");
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule